// File: doc/BRIEF.md
# Timeout-Driven Power State Controller

This block decides which of three power states a processor core occupies: RUN (fully operating), IDLE (core halted, interrupts still watched) and SLEEP (all on-chip activity off). A workload request and an interrupt line count as activity. A microsecond tick paces every timed action. Every state change is a timed transition. While a transition runs, the state output keeps showing the source state and a transition flag is raised. When the count of ticks for that pair of states runs out, the state output takes the destination.

Sleep is reached only after a long quiet period. With a nonzero threshold written into the timeout register, the core stays in RUN while it is quiet. It starts the shutdown only after that many consecutive quiet ticks. A threshold of zero turns sleep off: the core drops to IDLE as soon as activity stops. A built-in accumulator keeps a running energy estimate. On each tick it adds the power of the state shown. When a transition completes it adds the fixed cost of that transition. The sum stops at full scale.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pm_power_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block shows RUN (0), `in_transition` low, `gate_en` low and `energy` zero. The timeout threshold resets to zero.
- R2: `pstate` uses the codes RUN=0, IDLE=1, SLEEP=2. A transition starts on a clock edge and `in_transition` is high from that edge on. `pstate` keeps the source code until the edge where the transition completes; on that edge it takes the destination and `in_transition` drops.
- R3: Transition times are counted only on clock edges with `tick_us` high. The defaults are RUN→IDLE 10, IDLE→RUN 10, RUN→SLEEP 90 and SLEEP→RUN 160000 ticks, all parameters.
- R4: With a threshold of zero, an edge in settled RUN with no activity (`work_req`=0 and `irq`=0) starts RUN→IDLE. SLEEP is never entered.
- R5: With a nonzero threshold N, settled RUN with no activity counts quiet ticks. The tick that brings the count to N starts RUN→SLEEP. Any active edge clears the count.
- R6: Activity in settled IDLE starts IDLE→RUN. Activity in settled SLEEP starts SLEEP→RUN. Neither state leads anywhere except RUN.
- R7: Activity during RUN→SLEEP does not abort it. The shutdown completes, and SLEEP→RUN starts on the very next edge.
- R8: `gate_en` is high exactly when the block is settled (not in transition) in IDLE or SLEEP.
- R9: On every tick edge, `energy` grows by the dwell power of the shown state, in units of 1/256 nJ: RUN 102400, IDLE 12800, SLEEP 41.
- R10: On the edge a transition completes, the transition cost is added as well: RUN↔IDLE 1024000 each way, RUN→SLEEP 1280000, SLEEP→RUN 16384000000.
- R11: `energy` saturates at 2^EW−1 and never decreases.
- R12: An edge with `thr_we` high loads `thr_wdata` into the threshold. The new value governs decisions from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| work_req | input | 1 | Workload has work pending |
| irq | input | 1 | Interrupt request |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | TW | Quiet-tick threshold; zero disables sleep |
| pstate | output | 2 | Shown power state (0 RUN, 1 IDLE, 2 SLEEP) |
| in_transition | output | 1 | A timed transition is running |
| gate_en | output | 1 | Clock gate / power-down enable |
| energy | output | EW | Accumulated energy, 1/256 nJ units, saturating |

## Verification
The bound checker watches these properties on every cycle:
- the state code is legal;
- `pstate` stays fixed while a transition runs and changes only as one ends;
- IDLE and SLEEP exit only to RUN;
- `gate_en` agrees with the settled state;
- `energy` never falls.

Other behaviour needs the bench's scenarios and its cycle-level reference model:
- exact transition lengths under sparse ticks;
- the quiet-tick timeout and its restart on activity;
- the wake that follows an uninterrupted shutdown;
- the amounts added to `energy`, and its saturation.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_SLEEP = 2'd2
  } pstate_e;
endpackage

// File: rtl/pm_lat_timer.sv
// Counts ticks of a running transition and flags the completing tick.
module pm_lat_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_comb done = busy && tick && ((cnt_q + CW'(1)) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy && tick) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pm_idle_timer.sv
// Counts consecutive quiet ticks; fires when the programmed threshold is met.
module pm_idle_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [TW-1:0] thr,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (TW+1)'(1);
    expire  = !clear && tick && (thr != '0) && (cnt_inc >= {1'b0, thr});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear || expire) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_inc[TW-1:0];
  end
endmodule

// File: rtl/pm_energy_acc.sv
// Saturating energy estimate: dwell power per tick plus cost per completed transition.
module pm_energy_acc
  import pm_pkg::*;
#(
  parameter int              EW      = 48,
  parameter longint unsigned P_RUN   = 64'd102400,
  parameter longint unsigned P_IDLE  = 64'd12800,
  parameter longint unsigned P_SLEEP = 64'd41,
  parameter longint unsigned C_RI    = 64'd1024000,
  parameter longint unsigned C_IR    = 64'd1024000,
  parameter longint unsigned C_RS    = 64'd1280000,
  parameter longint unsigned C_SR    = 64'd16384000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  pstate_e       st,
  input  pstate_e       dst,
  input  logic          done,
  output logic [EW-1:0] energy
);
  localparam logic [64:0] EMAX = (65'd1 << EW) - 65'd1;

  logic [63:0] dwell, cost, inc;
  logic [64:0] sum, nxt;

  always_comb begin
    unique case (st)
      PS_IDLE:  dwell = P_IDLE;
      PS_SLEEP: dwell = P_SLEEP;
      default:  dwell = P_RUN;
    endcase
    unique case (dst)
      PS_IDLE:  cost = C_RI;
      PS_SLEEP: cost = C_RS;
      default:  cost = (st == PS_SLEEP) ? C_SR : C_IR;
    endcase
    inc = (tick ? dwell : 64'd0) + (done ? cost : 64'd0);
    sum = {1'b0, 64'(energy)} + {1'b0, inc};
    nxt = (sum > EMAX) ? EMAX : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) energy <= '0;
    else        energy <= nxt[EW-1:0];
  end
endmodule

// File: rtl/pm_power_ctrl.sv
// Three-state power controller with timed transitions and a quiet-tick sleep gate.
module pm_power_ctrl
  import pm_pkg::*;
#(
  parameter int              TW      = 20,
  parameter int              CW      = 18,
  parameter int              LAT_RI  = 10,
  parameter int              LAT_IR  = 10,
  parameter int              LAT_RS  = 90,
  parameter int              LAT_SR  = 160000,
  parameter int              EW      = 48,
  parameter longint unsigned P_RUN   = 64'd102400,
  parameter longint unsigned P_IDLE  = 64'd12800,
  parameter longint unsigned P_SLEEP = 64'd41,
  parameter longint unsigned C_RI    = 64'd1024000,
  parameter longint unsigned C_IR    = 64'd1024000,
  parameter longint unsigned C_RS    = 64'd1280000,
  parameter longint unsigned C_SR    = 64'd16384000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          work_req,
  input  logic          irq,
  input  logic          tick_us,
  input  logic          thr_we,
  input  logic [TW-1:0] thr_wdata,
  output logic [1:0]    pstate,
  output logic          in_transition,
  output logic          gate_en,
  output logic [EW-1:0] energy
);
  pstate_e       st_q, dst_q, dst_n;
  logic          pend_q, act, start, tbusy, done, expire, idle_clr;
  logic [TW-1:0] thr_q;
  logic [CW-1:0] limit;

  always_comb begin
    act   = work_req | irq;
    start = 1'b0;
    dst_n = dst_q;
    if (!tbusy) begin
      unique case (st_q)
        PS_RUN: begin
          if (!act && thr_q == '0) begin start = 1'b1; dst_n = PS_IDLE;  end
          else if (expire)         begin start = 1'b1; dst_n = PS_SLEEP; end
        end
        PS_IDLE:  if (act)          begin start = 1'b1; dst_n = PS_RUN; end
        PS_SLEEP: if (act || pend_q) begin start = 1'b1; dst_n = PS_RUN; end
        default: ;
      endcase
    end
  end

  // transition length selected by the running (source, destination) pair
  always_comb begin
    unique case (dst_q)
      PS_IDLE:  limit = CW'(LAT_RI);
      PS_SLEEP: limit = CW'(LAT_RS);
      default:  limit = (st_q == PS_SLEEP) ? CW'(LAT_SR) : CW'(LAT_IR);
    endcase
  end

  always_comb idle_clr = act || (st_q != PS_RUN) || tbusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_RUN;
      dst_q  <= PS_RUN;
      pend_q <= 1'b0;
      thr_q  <= '0;
    end else begin
      if (done)   st_q  <= dst_q;
      if (start)  dst_q <= dst_n;
      if (start)  pend_q <= 1'b0;
      else if (tbusy && st_q == PS_RUN && dst_q == PS_SLEEP && act) pend_q <= 1'b1;
      if (thr_we) thr_q <= thr_wdata;
    end
  end

  pm_lat_timer #(.CW(CW)) u_lat (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick_us),
    .limit(limit), .busy(tbusy), .done(done)
  );

  pm_idle_timer #(.TW(TW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clear(idle_clr), .tick(tick_us),
    .thr(thr_q), .expire(expire)
  );

  pm_energy_acc #(
    .EW(EW), .P_RUN(P_RUN), .P_IDLE(P_IDLE), .P_SLEEP(P_SLEEP),
    .C_RI(C_RI), .C_IR(C_IR), .C_RS(C_RS), .C_SR(C_SR)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .st(st_q), .dst(dst_q),
    .done(done), .energy(energy)
  );

  always_comb begin
    pstate        = st_q;
    in_transition = tbusy;
    gate_en       = (st_q != PS_RUN) && !tbusy;
  end
endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk #(
  parameter int EW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pstate,
  input logic          in_transition,
  input logic          gate_en,
  input logic [EW-1:0] energy
);
  assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pstate != 2'd3);

  assert_hold_in_transition_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_transition |=> (!in_transition || $stable(pstate)));

  assert_change_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pstate) |-> ($past(in_transition) && !in_transition));

  assert_idle_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pstate) == 2'd1 && pstate != 2'd1) |-> pstate == 2'd0);

  assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pstate) == 2'd2 && pstate != 2'd2) |-> pstate == 2'd0);

  assert_gate_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en == (pstate != 2'd0 && !in_transition));

  assert_energy_monotone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> energy >= $past(energy));
endmodule

bind pm_power_ctrl pm_power_ctrl_chk #(.EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pstate(pstate), .in_transition(in_transition),
  .gate_en(gate_en), .energy(energy)
);

// File: tb/pm_power_ctrl_test.sv
module pm_power_ctrl_test;
  localparam int TW = 8;
  localparam int L_RI = 3, L_IR = 4, L_RS = 6, L_SR = 9;
  localparam int EW = 32;
  localparam longint EMAXV = (64'd1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic work_req = 1'b0, irq = 1'b0, tick_us = 1'b0, thr_we = 1'b0;
  logic [TW-1:0] thr_wdata = '0;
  logic [1:0] pstate;
  logic in_transition, gate_en;
  logic [EW-1:0] energy;

  always #4 clk = ~clk;

  pm_power_ctrl #(
    .TW(TW), .CW(8), .LAT_RI(L_RI), .LAT_IR(L_IR), .LAT_RS(L_RS), .LAT_SR(L_SR), .EW(EW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .work_req(work_req), .irq(irq), .tick_us(tick_us),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .pstate(pstate),
    .in_transition(in_transition), .gate_en(gate_en), .energy(energy)
  );

  int vectors = 0, fails = 0, cyc = 0, sparse = 0;
  string tag = "R1";

  // reference model state
  int m_st = 0, m_dst = 0, m_cnt = 0, m_quiet = 0, m_thr = 0;
  bit m_tr = 0, m_pend = 0;
  longint m_e = 0;

  function automatic int lat_of(int s, int d);
    if (d == 1) return L_RI;
    if (d == 2) return L_RS;
    return (s == 2) ? L_SR : L_IR;
  endfunction

  function automatic longint cost_of(int s, int d);
    if (d == 1) return 1024000;
    if (d == 2) return 1280000;
    return (s == 2) ? 64'd16384000000 : 1024000;
  endfunction

  function automatic longint pw_of(int s);
    if (s == 0) return 102400;
    if (s == 1) return 12800;
    return 41;
  endfunction

  always @(posedge clk) begin
    bit act;
    longint inc;
    int n_st, n_dst, n_cnt, n_quiet;
    bit n_tr, n_pend;
    if (!rst_n) begin
      m_st = 0; m_dst = 0; m_cnt = 0; m_quiet = 0; m_thr = 0;
      m_tr = 0; m_pend = 0; m_e = 0;
    end else begin
      act = work_req | irq;
      inc = tick_us ? pw_of(m_st) : 0;
      n_st = m_st; n_dst = m_dst; n_cnt = m_cnt; n_tr = m_tr; n_pend = m_pend;
      n_quiet = 0;
      if (m_tr) begin
        if (m_st == 0 && m_dst == 2 && act) n_pend = 1;
        if (tick_us) begin
          n_cnt = m_cnt + 1;
          if (n_cnt == lat_of(m_st, m_dst)) begin
            inc += cost_of(m_st, m_dst);
            n_st = m_dst; n_tr = 0; n_cnt = 0;
          end
        end
      end else if (m_st == 0) begin
        if (!act && m_thr == 0) begin n_tr = 1; n_dst = 1; n_cnt = 0; n_pend = 0; end
        else if (!act) begin
          n_quiet = m_quiet;
          if (tick_us) begin
            n_quiet = m_quiet + 1;
            if (n_quiet >= m_thr) begin n_tr = 1; n_dst = 2; n_cnt = 0; n_pend = 0; n_quiet = 0; end
          end
        end
      end else if (m_st == 1) begin
        if (act) begin n_tr = 1; n_dst = 0; n_cnt = 0; n_pend = 0; end
      end else begin
        if (act || m_pend) begin n_tr = 1; n_dst = 0; n_cnt = 0; n_pend = 0; end
      end
      m_st = n_st; m_dst = n_dst; m_cnt = n_cnt; m_tr = n_tr; m_pend = n_pend;
      m_quiet = n_quiet;
      m_e = m_e + inc;
      if (m_e > EMAXV) m_e = EMAXV;
      if (thr_we) m_thr = thr_wdata;
    end
  end

  task automatic cmp(string what, longint got, longint exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s]: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // compare away from the active edge; drive tick on the same falling edge
  always @(negedge clk) begin
    cyc++;
    cmp("pstate R2", pstate, m_st);
    cmp("in_transition R3", in_transition, m_tr);
    cmp("gate_en R8", gate_en, (m_st != 0) && !m_tr);
    cmp("energy R9 R10 R11", energy, m_e);
    tick_us <= (sparse == 0) ? 1'b1 : (cyc % 3 == 0);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got no end expected end");
    summary();
    $finish;
  end

  initial begin
    tag = "R1"; run(4);
    rst_n = 1'b1;
    tag = "R4"; work_req = 1'b1; run(5);
    work_req = 1'b0; run(12);
    tag = "R6"; irq = 1'b1; run(1); irq = 1'b0;
    work_req = 1'b1; run(8);
    tag = "R3"; sparse = 1; work_req = 1'b0; run(20);
    work_req = 1'b1; run(20);
    sparse = 0;
    tag = "R12"; thr_we = 1'b1; thr_wdata = 8'd5; run(1); thr_we = 1'b0; run(2);
    tag = "R5"; work_req = 1'b0; run(3); work_req = 1'b1; run(1);
    work_req = 1'b0; run(20);
    tag = "R11"; irq = 1'b1; run(1); irq = 1'b0; work_req = 1'b1; run(20);
    tag = "R7"; work_req = 1'b0; run(6); work_req = 1'b1; run(3);
    work_req = 1'b0; run(40);
    tag = "R10"; thr_we = 1'b1; thr_wdata = 8'd0; run(1); thr_we = 1'b0;
    irq = 1'b1; run(1); irq = 1'b0; run(30);
    summary();
    $finish;
  end
endmodule